// File: doc/BRIEF.md
# Pattern Fill Unit with Colour Expansion

This unit paints a destination rectangle in pixel memory by repeating an 8x8 pattern across it. The pattern already sits in memory at a source address. When a fill is started, the unit first copies the pattern into an internal buffer. It then walks the rectangle one pixel per cycle, row by row. Each pixel's address is the destination start plus the line number times the pitch plus the horizontal offset. All pixels are 8 bits wide.

A mode byte controls the fill:
- Bit 6 requests a pattern fill. A start request without this bit does nothing.
- Bit 7 selects colour expansion. In this mode the pattern is eight monochrome bytes, and each bit picks either the foreground colour or the background colour. Without bit 7 the pattern is 64 literal pixel bytes.
- Bit 3 enables transparency. In expansion mode it leaves background pixels unwritten.

A solid fill is a pattern fill with a uniform pattern. Software sets up the registers, pulses `start`, and polls `busy`.

Top module: `patfill_engine`

## Requirements
- R1: While reset is held, `busy` and `mem_en` are 0.
- R2: A `start` pulse while idle with mode bit 6 clear has no effect. `busy` stays 0 and no memory access is issued.
- R3: A `start` pulse while idle with mode bit 6 set raises `busy` in the next cycle. In that cycle pattern loading begins: one read per cycle with `mem_we`=0, at source+0, +1, and so on. The unit reads 8 bytes when mode bit 7 is set and 64 bytes when it is clear. Read data is expected on `mem_rdata` one cycle after the read.
- R4: Right after the last pattern read, the unit spends one cycle per destination pixel. It moves left to right along a line and then to the next line. Each pixel's address is dst + y*pitch + x, and `mem_we`=1 for every one of these cycles.
- R5: With mode bit 7 clear, pixel (x,y) receives pattern byte (y mod 8)*8 + (x mod 8).
- R6: With mode bit 7 set, pixel (x,y) uses bit 7-(x mod 8) of pattern byte (y mod 8). The most significant bit is the leftmost pixel. A 1 bit writes the foreground colour and a 0 bit writes the background colour.
- R7: With mode bits 7 and 3 both set, a pixel whose pattern bit is 0 still takes its cycle, but `mem_en` is 0 in that cycle. Mode bit 3 has no effect when bit 7 is clear.
- R8: `busy` stays 1 through the cycle of the final pixel and is 0 in the cycle after it.
- R9: While busy, a `start` pulse and any change to the mode, address, pitch, size or colour inputs have no effect on the fill in progress.
- R10: The width and height inputs hold the pixel count minus one, so 0 means a single pixel or a single line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a fill |
| mode | input | 8 | Bit 6 pattern fill, bit 7 colour expand, bit 3 transparency |
| src_addr | input | AW | Pattern location in pixel memory |
| dst_addr | input | AW | Address of the top-left destination pixel |
| dst_pitch | input | PW | Address step between destination lines |
| width_m1 | input | XW | Rectangle width minus one |
| height_m1 | input | YW | Rectangle height minus one |
| fg_color | input | 8 | Colour for 1 bits in expansion mode |
| bg_color | input | 8 | Colour for 0 bits in expansion mode |
| busy | output | 1 | Fill in progress |
| mem_en | output | 1 | Memory access valid this cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Pixel data to write |
| mem_rdata | input | 8 | Read data, valid one cycle after a read |

## Verification
The hardest cases to reach from the ports are the ones that depend on the pattern wrapping in both directions. This includes the last pattern row and column being used, and transparent slots landing next to written ones. To reach them, the rectangles are wider and taller than eight pixels and have odd sizes, and the patterns are irregular so that a swapped row, column or bit order produces a visible mismatch. A fill in progress is disturbed partway through: the bench issues another start and rewrites every configuration input. This shows that the latched setup alone drives the remaining cycles.

// File: rtl/patfill_engine.sv
module patfill_engine #(
  parameter int AW = 21,
  parameter int PW = 13,
  parameter int XW = 11,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    mode,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [PW-1:0] dst_pitch,
  input  logic [XW-1:0] width_m1,
  input  logic [YW-1:0] height_m1,
  input  logic [7:0]    fg_color,
  input  logic [7:0]    bg_color,
  output logic          busy,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int PBYTES = 64;
  localparam int IW = $clog2(PBYTES);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WRITE} st_t;
  st_t st;

  logic [7:0]    pbuf [PBYTES];
  logic [IW-1:0] ld_idx, rd_slot;
  logic          rd_pend;
  logic [XW-1:0] px;
  logic [YW-1:0] py;
  logic [AW-1:0] row_base;

  logic          c_exp, c_trn;
  logic [AW-1:0] c_src;
  logic [PW-1:0] c_pitch;
  logic [XW-1:0] c_wm1;
  logic [YW-1:0] c_hm1;
  logic [7:0]    c_fg, c_bg;

  wire launch  = start && mode[6] && (st == S_IDLE);
  wire ld_last = c_exp ? (ld_idx == IW'(7)) : (ld_idx == IW'(PBYTES - 1));
  wire px_last = (px == c_wm1);
  wire all_done = px_last && (py == c_hm1);

  wire [7:0] mono_row = pbuf[{3'b000, py[2:0]}];
  wire       pat_bit  = mono_row[3'd7 - px[2:0]];
  wire       skip_px  = c_exp && c_trn && !pat_bit;

  assign busy      = (st != S_IDLE);
  assign mem_we    = (st == S_WRITE);
  assign mem_en    = (st == S_LOAD) || ((st == S_WRITE) && !skip_px);
  assign mem_addr  = (st == S_LOAD) ? c_src + AW'(ld_idx) : row_base + AW'(px);
  assign mem_wdata = c_exp ? (pat_bit ? c_fg : c_bg) : pbuf[{py[2:0], px[2:0]}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ld_idx   <= '0;
      rd_pend  <= 1'b0;
      rd_slot  <= '0;
      px       <= '0;
      py       <= '0;
      row_base <= '0;
      c_exp    <= 1'b0;
      c_trn    <= 1'b0;
      c_src    <= '0;
      c_pitch  <= '0;
      c_wm1    <= '0;
      c_hm1    <= '0;
      c_fg     <= '0;
      c_bg     <= '0;
    end else begin
      rd_pend <= (st == S_LOAD);
      rd_slot <= ld_idx;
      unique case (st)
        S_IDLE: if (launch) begin
          st       <= S_LOAD;
          ld_idx   <= '0;
          c_exp    <= mode[7];
          c_trn    <= mode[3];
          c_src    <= src_addr;
          c_pitch  <= dst_pitch;
          c_wm1    <= width_m1;
          c_hm1    <= height_m1;
          c_fg     <= fg_color;
          c_bg     <= bg_color;
          row_base <= dst_addr;
          px       <= '0;
          py       <= '0;
        end
        S_LOAD: begin
          ld_idx <= ld_idx + 1'b1;
          if (ld_last) st <= S_WRITE;
        end
        S_WRITE: begin
          if (all_done) begin
            st <= S_IDLE;
          end else if (px_last) begin
            px       <= '0;
            py       <= py + 1'b1;
            row_base <= row_base + AW'(c_pitch);
          end else begin
            px <= px + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rd_pend) pbuf[rd_slot] <= mem_rdata;
  end
endmodule

module patfill_engine_chk #(
  parameter int AW = 21,
  parameter int XW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    mode,
  input logic          busy,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    st,
  input logic [XW-1:0] px,
  input logic [7:0]    c_fg
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  a_r3_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode[6] && !busy) |=> busy);

  a_r3_load_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (mem_en && !mem_we));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 2'd2) && $past(st == 2'd2) && (px != '0)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r8_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r9_colour_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 2'd2) && $past(st == 2'd2)) |-> $stable(c_fg));
endmodule

bind patfill_engine patfill_engine_chk #(.AW(AW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .st(st),
  .px(px), .c_fg(c_fg)
);

// File: tb/patfill_engine_tb.sv
module patfill_engine_tb;
  localparam int AW = 21;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] mode = 0, fg_color = 0, bg_color = 0, mem_rdata = 0;
  logic [AW-1:0] src_addr = 0, dst_addr = 0;
  logic [12:0] dst_pitch = 0;
  logic [10:0] width_m1 = 0;
  logic [9:0] height_m1 = 0;
  logic busy, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  patfill_engine u_dut (.*);

  always #4 clk = ~clk;

  typedef struct {bit en; bit we; int addr; int data; string dtag; string etag;} ent_t;
  ent_t q[$];
  logic [7:0] mem [4096];
  int checks = 0, errors = 0, cyc = 0;
  string idle_tag = "R1";

  always @(posedge clk) begin
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_en && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #3;
    cyc++;
    if (!rst_n) begin
      chk(busy === 1'b0 && mem_en === 1'b0, "R1", {busy, mem_en}, 0);
    end else if (q.size() > 0) begin
      ent_t e;
      e = q.pop_front();
      chk(busy === 1'b1, "R8", busy, 1);
      chk(mem_en === e.en, e.etag, mem_en, e.en);
      chk(mem_we === e.we, e.we ? "R4" : "R3", mem_we, e.we);
      if (e.en) chk(mem_addr === AW'(e.addr), e.we ? "R4" : "R3", mem_addr, e.addr);
      if (e.en && e.we) chk(mem_wdata === 8'(e.data), e.dtag, mem_wdata, e.data);
    end else begin
      chk(busy === 1'b0 && mem_en === 1'b0, idle_tag, {busy, mem_en}, 0);
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fill(input logic [7:0] md, input int src, input int dst, input int pitch,
                      input int w, input int h, input logic [7:0] fg, input logic [7:0] bg,
                      input bit disturb);
    bit ex;
    int n;
    @(negedge clk);
    mode = md; src_addr = AW'(src); dst_addr = AW'(dst); dst_pitch = 13'(pitch);
    width_m1 = 11'(w - 1); height_m1 = 10'(h - 1); fg_color = fg; bg_color = bg;
    start = 1;
    ex = md[7];
    n = ex ? 8 : 64;
    for (int i = 0; i < n; i++) q.push_back('{1, 0, src + i, 0, "R3", "R3"});
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        logic [7:0] pb;
        bit b;
        ent_t e;
        pb = mem[12'(src + (ex ? (y % 8) : (y % 8) * 8 + (x % 8)))];
        b = pb[7 - (x % 8)];
        e.we = 1;
        e.addr = dst + y * pitch + x;
        e.en = !(ex && md[3] && !b);
        e.data = ex ? (b ? fg : bg) : pb;
        e.dtag = ex ? "R6" : "R5";
        e.etag = "R7";
        q.push_back(e);
      end
    @(negedge clk);
    start = 0;
    if (disturb) begin
      // R9: restart request and new setup while busy
      repeat (5) @(negedge clk);
      mode = 8'hC8; src_addr = 21'h300; dst_addr = 21'h10; dst_pitch = 13'd3;
      width_m1 = 11'd2; height_m1 = 10'd1; fg_color = ~fg; bg_color = ~bg;
      start = 1;
      @(negedge clk);
      start = 0;
      repeat (20) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + (i >> 3));
    for (int i = 0; i < 8; i++) mem[12'h100 + i] = 8'({i[2:0], 5'b0} ^ 8'h5A ^ 8'(i * 17));
    for (int i = 0; i < 8; i++) mem[12'h180 + i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle_tag = "R8";
    // R5, R4: colour pattern, wraps in both directions
    fill(8'h40, 'h040, 'h800, 20, 11, 10, 8'h00, 8'h00, 0);
    // R6: monochrome expansion, with R9 disturbance
    fill(8'hC0, 'h100, 'hA00, 16, 13, 9, 8'hE1, 8'h1E, 1);
    // R7: expansion with transparency
    fill(8'hC8, 'h100, 'hC00, 17, 10, 11, 8'h3C, 8'hC3, 0);
    // R7: transparency bit ignored for colour patterns
    fill(8'h48, 'h040, 'hE00, 9, 9, 9, 8'h00, 8'h00, 0);
    // R10: single pixel, solid pattern
    fill(8'hC0, 'h180, 'hF80, 5, 1, 1, 8'h77, 8'h00, 0);
    // R10: single line of pixels
    fill(8'hC0, 'h100, 'hF90, 5, 12, 1, 8'h77, 8'h11, 0);
    // R2: start without pattern-fill bit
    idle_tag = "R2";
    @(negedge clk);
    mode = 8'h80;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule